// File: doc/BRIEF.md
# Event Timer with Shared Prescaler

This block is an 8-bit timer paired with a watchdog counter. Both share one programmable prescaler. The timer counts either instruction-cycle enables or selected edges of an external input pin. The watchdog counts ticks from its own free-running oscillator, which reaches the block as a single-cycle tick input. A 6-bit control value decides four things: where the timer's events come from, which pin edge counts, which of the two counters receives the divided events, and the division ratio.

The prescaler serves exactly one consumer at a time. The other consumer takes its events undivided. The prescaler is a down counter, and its present contents are always visible on an output.

The timer can be written directly. Timer wraps and watchdog wraps each produce a one-cycle pulse. The watchdog time-out pulse is meant to reset the surrounding system.

Top module: `tmr_prescale`

## Requirements
- R1: While reset is asserted, and in the first cycle after it: `tmr_q` is 0, `tmr_ovf` and `wdt_timeout` are 0, and `pre_count` holds the reload value for the current control setting.
- R2: Control encoding:
  - `ctrl[2:0]` is the ratio code k.
  - `ctrl[3]`=1 gives the prescaler to the watchdog; 0 gives it to the timer.
  - `ctrl[4]`=1 selects falling pin edges; 0 selects rising.
  - `ctrl[5]`=1 makes the external pin the timer source; 0 selects `icyc_en`.
- R3: While the prescaler serves the timer, the timer advances once every 2^(k+1) source events.
- R4: While the prescaler serves the watchdog, the timer advances on every source event.
- R5: The external pin is synchronized through two flops. Each selected edge gives exactly one event, on the third clock edge after the pin changes. The opposite edge is ignored, and `icyc_en` is ignored in external mode.
- R6: `tmr_ovf` is high for exactly one cycle, the cycle after the timer wraps from 8'hFF to 8'h00. During that cycle `tmr_q` reads 0.
- R7: A `tmr_wr` cycle loads `tmr_wdata` into the timer at the next edge. Any increment due in that cycle is discarded, and the prescaler is reloaded.
- R8: `pre_count` decrements on each event it receives. An event arriving at 0 passes one divided event onward and reloads the counter. The reload value is 2^(k+1)-1 when the prescaler serves the timer and 2^k-1 when it serves the watchdog.
- R9: A change of `ctrl[3]` reloads the prescaler for the new assignment. No divided event is passed in that cycle.
- R10: With `wdt_en` high, the WDT_W-bit watchdog counter advances on `wdt_tick`. It is divided by 2^k when it holds the prescaler and undivided otherwise, independent of `icyc_en`. `wdt_timeout` pulses for one cycle after the counter wraps from all ones.
- R11: While `wdt_en` is low, the watchdog counter is held at zero and `wdt_timeout` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| icyc_en | input | 1 | Instruction-cycle enable (oscillator/4) |
| ext_pin | input | 1 | Asynchronous external timer input |
| wdt_tick | input | 1 | One-cycle tick from the watchdog oscillator |
| wdt_en | input | 1 | Watchdog enable |
| ctrl | input | 6 | Control value, encoded as in R2 |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write data |
| tmr_q | output | 8 | Timer value |
| tmr_ovf | output | 1 | Timer wrap pulse |
| wdt_timeout | output | 1 | Watchdog time-out pulse |
| pre_count | output | 8 | Present prescaler count |

## Verification
The prescaler count is always on a port, so a wrong decrement or a missed reload shows on `pre_count` in the next cycle. The timer, however, shows it only when the divided event arrives, up to 256 source events later. A wrong watchdog counter never appears at the ports until the time-out pulse comes early or late, which can be thousands of ticks later. For that reason, directed runs force the shortest ratio and drive a full wrap. A fault in the pin synchronizer shows as a timer step one cycle off or a step on the wrong edge, three clocks after the pin moves.

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int TMR_W = 8,
  parameter int PRE_W = 8,
  parameter int WDT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             icyc_en,
  input  logic             ext_pin,
  input  logic             wdt_tick,
  input  logic             wdt_en,
  input  logic [5:0]       ctrl,
  input  logic             tmr_wr,
  input  logic [TMR_W-1:0] tmr_wdata,
  output logic [TMR_W-1:0] tmr_q,
  output logic             tmr_ovf,
  output logic             wdt_timeout,
  output logic [PRE_W-1:0] pre_count
);
  localparam logic [TMR_W-1:0] TMR_MAX = '1;
  localparam logic [WDT_W-1:0] WDT_MAX = '1;

  logic [2:0] ratio;
  logic       to_wdt, fall_sel, src_ext;
  assign ratio    = ctrl[2:0];
  assign to_wdt   = ctrl[3];
  assign fall_sel = ctrl[4];
  assign src_ext  = ctrl[5];

  logic sync1, sync2, sync_d;
  logic asg_q;
  logic [WDT_W-1:0] wdt_cnt;

  logic [PRE_W:0] rl_wide;
  logic [PRE_W-1:0] rl;
  assign rl_wide = to_wdt ? ((PRE_W+1)'(1) << ratio) - 1'b1
                          : ((PRE_W+1)'(2) << ratio) - 1'b1;
  assign rl = rl_wide[PRE_W-1:0];

  logic ext_evt, tmr_evt, wdt_evt, pre_in, reload, pre_pulse, tmr_step, wdt_step;
  assign ext_evt   = fall_sel ? (sync_d & ~sync2) : (sync2 & ~sync_d);
  assign tmr_evt   = src_ext ? ext_evt : icyc_en;
  assign wdt_evt   = wdt_en & wdt_tick;
  assign pre_in    = to_wdt ? wdt_evt : tmr_evt;
  assign reload    = tmr_wr | (to_wdt != asg_q);
  assign pre_pulse = pre_in & (pre_count == '0) & ~reload;
  assign tmr_step  = ~tmr_wr & (to_wdt ? tmr_evt : pre_pulse);
  assign wdt_step  = wdt_en & (to_wdt ? pre_pulse : wdt_evt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1  <= 1'b0;
      sync2  <= 1'b0;
      sync_d <= 1'b0;
    end else begin
      sync1  <= ext_pin;
      sync2  <= sync1;
      sync_d <= sync2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_count <= rl;
      asg_q     <= to_wdt;
    end else begin
      asg_q <= to_wdt;
      if (reload)
        pre_count <= rl;
      else if (pre_in)
        pre_count <= (pre_count == '0) ? rl : pre_count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q   <= '0;
      tmr_ovf <= 1'b0;
    end else begin
      tmr_ovf <= tmr_step & (tmr_q == TMR_MAX);
      if (tmr_wr)
        tmr_q <= tmr_wdata;
      else if (tmr_step)
        tmr_q <= tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wdt_cnt     <= '0;
      wdt_timeout <= 1'b0;
    end else begin
      wdt_timeout <= wdt_step & (wdt_cnt == WDT_MAX);
      if (!wdt_en)
        wdt_cnt <= '0;
      else if (wdt_step)
        wdt_cnt <= wdt_cnt + 1'b1;
    end
  end

  p_ovf_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |-> (tmr_q == '0 && $past(tmr_q) == TMR_MAX));

  p_wr_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wr |=> (tmr_q == $past(tmr_wdata)));

  p_pre_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_in && !reload && pre_count != '0) |=> (pre_count == $past(pre_count) - 1'b1));

  p_reassign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (to_wdt != asg_q) |=> (pre_count == $past(rl)));

  p_wdt_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_en |=> (!wdt_timeout && wdt_cnt == '0));
endmodule

// File: tb/sim_tmr_prescale.sv
module sim_tmr_prescale;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic icyc_en = 1'b0, ext_pin = 1'b0, wdt_tick = 1'b0, wdt_en = 1'b0, tmr_wr = 1'b0;
  logic [5:0] ctrl = 6'd0;
  logic [7:0] tmr_wdata = 8'd0;
  logic [7:0] tmr_q, pre_count;
  logic tmr_ovf, wdt_timeout;

  always #10 clk = ~clk;

  tmr_prescale u0 (
    .clk(clk), .rst_n(rst_n), .icyc_en(icyc_en), .ext_pin(ext_pin),
    .wdt_tick(wdt_tick), .wdt_en(wdt_en), .ctrl(ctrl), .tmr_wr(tmr_wr),
    .tmr_wdata(tmr_wdata), .tmr_q(tmr_q), .tmr_ovf(tmr_ovf),
    .wdt_timeout(wdt_timeout), .pre_count(pre_count)
  );

  int checks = 0, errors = 0;
  string req = "R1";

  // expected-value model built from the requirements
  logic [7:0] m_tmr, m_pre;
  logic m_ovf, m_to, m_s1, m_s2, m_sd, m_asg;
  logic [7:0] m_wdt;

  function automatic logic [7:0] reload_val(input logic [5:0] c);
    int n;
    n = c[3] ? (1 << c[2:0]) : (2 << c[2:0]);
    return 8'(n - 1);
  endfunction

  function automatic logic pin_event(input logic [5:0] c, input logic s, input logic d);
    return c[4] ? (d && !s) : (s && !d);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tmr = 0; m_pre = reload_val(ctrl); m_ovf = 0; m_to = 0;
      m_s1 = 0; m_s2 = 0; m_sd = 0; m_asg = ctrl[3]; m_wdt = 0;
    end else begin
      logic tev, wev, pin, rl, pp, ts, ws;
      tev = ctrl[5] ? pin_event(ctrl, m_s2, m_sd) : icyc_en;
      wev = wdt_en && wdt_tick;
      pin = ctrl[3] ? wev : tev;
      rl  = tmr_wr || (ctrl[3] != m_asg);
      pp  = pin && (m_pre == 0) && !rl;
      ts  = !tmr_wr && (ctrl[3] ? tev : pp);
      ws  = wdt_en && (ctrl[3] ? pp : wev);
      m_ovf = ts && (m_tmr == 8'hFF);
      m_to  = ws && (m_wdt == 8'hFF);
      if (tmr_wr) m_tmr = tmr_wdata; else if (ts) m_tmr = m_tmr + 1;
      if (!wdt_en) m_wdt = 0; else if (ws) m_wdt = m_wdt + 1;
      if (rl) m_pre = reload_val(ctrl);
      else if (pin) m_pre = (m_pre == 0) ? reload_val(ctrl) : m_pre - 1;
      m_asg = ctrl[3];
      m_sd = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
    end
  end

  task automatic cmp_model();
    checks++;
    if (tmr_q !== m_tmr || tmr_ovf !== m_ovf || wdt_timeout !== m_to || pre_count !== m_pre) begin
      errors++;
      $display("FAIL %s: got tmr=%h ovf=%b to=%b pre=%h expected tmr=%h ovf=%b to=%b pre=%h",
               req, tmr_q, tmr_ovf, wdt_timeout, pre_count, m_tmr, m_ovf, m_to, m_pre);
    end
  endtask

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp_model();
    end
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: run hung");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int tos;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    // R1 reset state, ratio 0 with timer -> reload 1
    req = "R1";
    chk("R1 pre_count in reset", pre_count, 1);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 tmr_q", tmr_q, 0);
    chk("R1 pulses", {tmr_ovf, wdt_timeout}, 0);

    // R3/R8: divide by 2 on icyc_en, then ratio 2 (divide by 8)
    req = "R3";
    icyc_en = 1; cyc(10);
    chk("R3 ratio0 timer after 10 events", tmr_q, 5);
    req = "R8";
    ctrl = 6'b000010; tmr_wr = 1; tmr_wdata = 0; cyc(1); tmr_wr = 0;
    chk("R8 reload after write k=2", pre_count, 7);
    cyc(16);
    chk("R3 ratio2 after 16 events", tmr_q, 2);
    icyc_en = 0; cyc(3);
    chk("R3 no events, timer still", tmr_q, 2);

    // R9 reassign to watchdog
    req = "R9";
    ctrl = 6'b001011; cyc(1);
    chk("R9 reload for wdt k=3", pre_count, 7);

    // R4 every event counts when prescaler serves watchdog
    req = "R4";
    icyc_en = 1; cyc(7); icyc_en = 0; cyc(1);
    chk("R4 undivided timer", tmr_q, 9);

    // R5 external rising edges, icyc_en ignored
    req = "R5";
    ctrl = 6'b101000; icyc_en = 1; cyc(4);
    chk("R5 icyc ignored in ext mode", tmr_q, 9);
    ext_pin = 1; cyc(2);
    chk("R5 not yet after 2 edges", tmr_q, 9);
    cyc(1);
    chk("R5 rising counted on third edge", tmr_q, 10);
    ext_pin = 0; cyc(5);
    chk("R5 falling ignored", tmr_q, 10);
    ctrl = 6'b111000; ext_pin = 1; cyc(5);
    chk("R5 rising ignored in falling mode", tmr_q, 10);
    ext_pin = 0; cyc(5);
    chk("R5 falling counted", tmr_q, 11);
    icyc_en = 0;

    // R6/R7 wrap
    req = "R7";
    ctrl = 6'b001000; tmr_wr = 1; tmr_wdata = 8'hFE; icyc_en = 1; cyc(1); tmr_wr = 0;
    chk("R7 write load, increment dropped", tmr_q, 254);
    req = "R6";
    cyc(1);
    chk("R6 no pulse at FF", tmr_ovf, 0);
    cyc(1);
    chk("R6 pulse with zero", {tmr_ovf, tmr_q}, 9'h100);
    cyc(1);
    chk("R6 pulse one cycle", tmr_ovf, 0);
    icyc_en = 0;

    // R10 watchdog wrap, ratio 0, icyc_en idle (sleep)
    req = "R10";
    ctrl = 6'b001000; wdt_en = 1; wdt_tick = 1; tos = 0;
    for (int i = 0; i < 258; i++) begin
      @(negedge clk); cmp_model();
      if (wdt_timeout) tos++;
    end
    chk("R10 one timeout in 258 ticks", tos, 1);

    // R11 disable clears
    req = "R11";
    wdt_en = 0; tos = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); cmp_model();
      if (wdt_timeout) tos++;
    end
    chk("R11 no timeout while disabled", tos, 0);
    wdt_tick = 0;

    // R2 random mix of all controls
    req = "R2";
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      cmp_model();
      if ($urandom_range(63) == 0) ctrl = 6'($urandom);
      tmr_wr    = ($urandom_range(31) == 0);
      tmr_wdata = 8'($urandom);
      icyc_en   = ($urandom_range(1) == 0);
      if ($urandom_range(3) == 0) ext_pin = ~ext_pin;
      wdt_tick  = ($urandom_range(2) == 0);
      if ($urandom_range(99) == 0) wdt_en = ~wdt_en;
    end
    cyc(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule